// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns the bytes of a packet into a bit-serial HDLC stream for one channel. Bytes arrive on a valid/ready port with start and end markers. The serial output moves forward by one bit only on cycles where the bit-rate enable is high, so the same block works at any line rate that is slower than the core clock.

Between frames the line carries continuous flags. When a frame starts, the flag just completed serves as its opening flag. The payload follows, then a frame check sequence, then a closing flag. Zero-bit insertion covers the payload and the check sequence. It never applies to flags or to abort sequences.

The check sequence is either 16 bits (CRC-CCITT) or 32 bits (CRC-32). The width is chosen per frame from a configuration input, which is sampled when the frame starts. If the byte source runs dry in the middle of a frame, the framer sends an abort of eight ones and then goes back to flag fill.

Top module: `hdlc_tx_framer`

## Requirements
- R1: During reset `tx_bit` is 1 and `in_ready` is 0. After reset, with no frame pending, the line repeats the flag 0x7E, which appears on the wire as 0,1,1,1,1,1,1,0.
- R2: Each frame is bracketed by flags. Its bytes go out least significant bit first, in arrival order, followed by the check sequence.
- R3: After five consecutive ones in the payload or the check sequence, a 0 is inserted. This includes the case where the five ones end the check sequence. No 0 is ever inserted into a flag.
- R4: With `crc32_sel`=0 the check sequence is 16 bits. The register uses the reflected polynomial 0x8408, is preset to 0xFFFF, and its complement is sent least significant bit first. For the ASCII payload "123456789" the bytes on the wire are 0x6E then 0x90.
- R5: With `crc32_sel`=1 the check sequence is 32 bits. The register uses the reflected polynomial 0xEDB88320, is preset to all ones, and its complement is sent least significant bit first. For "123456789" the bytes on the wire are 0x26, 0x39, 0xF4, 0xCB.
- R6: If no byte is valid when one is needed in mid-frame, the framer sends eight consecutive ones without insertion and then returns to flag fill. A frame offered after that is sent intact.
- R7: `tx_bit` changes only on clock edges where `bit_en` is high.
- R8: A byte offered while idle without `in_sop` is accepted and discarded. No frame is produced from it.
- R9: `in_ready` is high only on a `bit_en` cycle at a byte boundary. A byte that carries `in_eop` is the last payload byte, and a single-byte frame is valid.
- R10: `crc32_sel` is sampled only when a frame starts. Changing it in mid-frame does not change that frame's check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| crc32_sel | input | 1 | 1 selects the 32-bit check sequence, 0 selects the 16-bit one |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The offered byte is taken on this edge |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | Marks the first byte of a frame |
| in_eop | input | 1 | Marks the last byte of a frame |
| tx_bit | output | 1 | Serial HDLC line output |

## Verification
The bench decodes the serial line on its own, removing inserted zeros and finding flags and aborts. It then compares each frame's bytes and check sequence against values it computes itself.

It uses the standard check string for both CRC widths, so a reversed bit order, a wrong preset or a missing complement gives wrong bytes. It uses all-ones payloads, where a framer that skipped insertion on the check sequence, or after the last check-sequence bit, would make the decoder lose alignment.

Other cases covered:
- **Mid-frame underrun:** a framer that kept sending stale data instead of an abort would show a corrupt frame.
- **Byte without a start marker while idle:** a framer that opened a frame on it would produce a spurious frame.
- **Enable held low:** a framer that did not hold the line while the enable is low would show a changing output.
- **Mode input flipped mid-frame:** a framer that did not latch the mode at frame start would send a check sequence of the wrong length.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [7:0]  FLAG   = 8'h7E,
  parameter logic [15:0] POLY16 = 16'h8408,
  parameter logic [31:0] POLY32 = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       crc32_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       tx_bit
);
  localparam int CNT_W = 6;
  localparam int RUN_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FCS, S_ABORT} st_t;

  st_t              st;
  logic [7:0]       sh;
  logic [CNT_W-1:0] cnt;
  logic [RUN_W-1:0] ones;
  logic [31:0]      crc;
  logic             m32;
  logic             last;

  logic        stuffable, stuff_now, cur_bit, fcs_last, fb;
  logic [31:0] poly, crc_step, preset;

  assign stuffable = (st == S_DATA) || (st == S_FCS);
  assign stuff_now = (ones == RUN_W'(5));
  assign fcs_last  = (cnt == (m32 ? CNT_W'(31) : CNT_W'(15)));
  assign poly      = m32 ? POLY32 : {16'h0, POLY16};
  assign preset    = crc32_sel ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  assign fb        = crc[0] ^ sh[0];
  assign crc_step  = {1'b0, crc[31:1]} ^ (fb ? poly : 32'h0);

  always_comb begin
    case (st)
      S_IDLE:  cur_bit = FLAG[cnt[2:0]];
      S_DATA:  cur_bit = sh[0];
      S_FCS:   cur_bit = ~crc[0];
      default: cur_bit = 1'b1;
    endcase
  end

  assign in_ready = bit_en && !stuff_now && (cnt == CNT_W'(7)) &&
                    ((st == S_IDLE) || (st == S_DATA && !last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      cnt    <= '0;
      ones   <= '0;
      crc    <= '1;
      m32    <= 1'b0;
      last   <= 1'b0;
      tx_bit <= 1'b1;
    end else if (bit_en) begin
      if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= cur_bit;
        ones   <= (stuffable && cur_bit) ? ones + RUN_W'(1) : '0;
        case (st)
          S_IDLE: begin
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              if (in_valid && in_sop) begin
                st   <= S_DATA;
                sh   <= in_data;
                last <= in_eop;
                m32  <= crc32_sel;
                crc  <= preset;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_DATA: begin
            crc <= crc_step;
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              if (last) begin
                st <= S_FCS;
              end else if (in_valid) begin
                sh   <= in_data;
                last <= in_eop;
              end else begin
                st <= S_ABORT;
              end
            end else begin
              sh  <= sh >> 1;
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_FCS: begin
            crc <= {1'b0, crc[31:1]};
            if (fcs_last) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: begin
            if (cnt == CNT_W'(7)) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        endcase
      end
    end
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R3
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_W'(5));

  // R2
  fcs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FCS && $past(st) != S_FCS) |-> ($past(st) == S_DATA && $past(last)));

  // R6
  abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABORT && $past(st) != S_ABORT) |-> ($past(st) == S_DATA && !$past(in_valid)));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(m32));
endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, hold = 1;
  logic crc32_sel = 0, in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 0;
  logic in_ready, tx_bit, bit_en;
  logic [1:0] div = 0;
  logic ben_d = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign bit_en = (div == 2'd2) && !hold;
  always @(posedge clk) ben_d <= bit_en;

  hdlc_tx_framer uut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crc32_sel(crc32_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .tx_bit(tx_bit));

  int checks = 0, fails = 0;
  logic [7:0] tx_buf [0:31];
  logic raw [0:63];
  int raw_n = 0;
  logic rxb [0:2047];
  int nb = 0, ones = 0, run_max = 0, stuffs = 0, flags = 0, aborts = 0, frames = 0, bad = 0;
  logic [7:0] rxf [0:63];
  int rx_len = 0;

  always @(negedge clk) begin
    if (rst_n && ben_d) begin
      if (raw_n < 64) raw[raw_n] = tx_bit;
      raw_n++;
      if (tx_bit) begin
        ones++;
        if (ones > run_max) run_max = ones;
        if (ones >= 7) begin
          if (ones == 7) aborts++;
          nb = 0;
        end else if (nb < 2048) begin
          rxb[nb] = 1'b1; nb++;
        end
      end else begin
        if (ones == 5) stuffs++;
        else if (ones == 6) begin
          flags++;
          if (nb > 7) begin
            if ((nb - 7) % 8 != 0 || nb - 7 > 512) bad++;
            else begin
              rx_len = (nb - 7) / 8;
              for (int i = 0; i < rx_len; i++)
                for (int j = 0; j < 8; j++) rxf[i][j] = rxb[8*i+j];
              frames++;
            end
          end
          nb = 0;
        end else if (nb < 2048) begin
          rxb[nb] = 1'b0; nb++;
        end
        ones = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input bit m32, input int n);
    logic [31:0] c = m32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic f = c[0] ^ tx_buf[i][j];
        c = c >> 1;
        if (f) c = c ^ (m32 ? 32'hEDB88320 : 32'h00008408);
      end
    return m32 ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic send_frame(input int n, input bit m32, input int gap_at, input int flip_at);
    @(negedge clk);
    crc32_sel = m32;
    for (int i = 0; i < n; i++) begin
      bit ok;
      if (i == gap_at) break;
      if (i == flip_at) crc32_sel = ~m32;
      in_valid = 1; in_data = tx_buf[i]; in_sop = (i == 0); in_eop = (i == n - 1);
      while (1) begin
        ok = in_ready;
        @(negedge clk);
        if (ok) break;
      end
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic wait_frame(input int prev);
    int t = 0;
    while (frames == prev && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic check_frame(input int n, input bit m32, input int prev, input string req);
    int fb = m32 ? 4 : 2;
    logic [31:0] exp = ref_fcs(m32, n);
    wait_frame(prev);
    chk(frames == prev + 1, req, "frame seen", frames, prev + 1);
    chk(bad == 0, req, "misaligned frames", bad, 0);
    chk(rx_len == n + fb, req, "frame length", rx_len, n + fb);
    for (int i = 0; i < n; i++)
      chk(rxf[i] == tx_buf[i], req, $sformatf("payload byte %0d", i), rxf[i], tx_buf[i]);
    for (int k = 0; k < fb; k++)
      chk(rxf[n+k] == exp[8*k +: 8], req, $sformatf("fcs byte %0d", k), rxf[n+k], exp[8*k +: 8]);
  endtask

  task automatic load_check_string();
    for (int i = 0; i < 9; i++) tx_buf[i] = 8'h31 + 8'(i);
  endtask

  task automatic t_reset();
    rst_n = 0; hold = 1;
    repeat (4) @(negedge clk);
    chk(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    rst_n = 1; hold = 0;
  endtask

  task automatic t_idle();
    bit ok = 1;
    while (raw_n < 32) @(negedge clk);
    for (int i = 0; i < 32; i++)
      if (raw[i] != ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1)) ok = 0;
    chk(ok, "R1", "idle flag pattern", ok, 1);
    chk(frames == 0, "R1", "no frame while idle", frames, 0);
  endtask

  task automatic t_ccitt_vector();
    int p = frames;
    load_check_string();
    send_frame(9, 0, -1, -1);
    check_frame(9, 0, p, "R4");
    chk(rxf[9] == 8'h6E && rxf[10] == 8'h90, "R4", "known 16-bit fcs", {rxf[10], rxf[9]}, 16'h906E);
  endtask

  task automatic t_crc32_vector();
    int p = frames;
    load_check_string();
    send_frame(9, 1, -1, -1);
    check_frame(9, 1, p, "R5");
    chk({rxf[12], rxf[11], rxf[10], rxf[9]} == 32'hCBF43926, "R5", "known 32-bit fcs",
        {rxf[12], rxf[11], rxf[10], rxf[9]}, 32'hCBF43926);
  endtask

  task automatic t_all_ones();
    int p = frames, s0 = stuffs;
    for (int i = 0; i < 6; i++) tx_buf[i] = 8'hFF;
    run_max = 0;
    send_frame(6, 1, -1, -1);
    check_frame(6, 1, p, "R3");
    chk(stuffs - s0 >= 9, "R3", "inserted zeros", stuffs - s0, 9);
    chk(run_max == 6, "R3", "longest run of ones", run_max, 6);
    p = frames;
    send_frame(6, 0, -1, -1);
    check_frame(6, 0, p, "R3");
  endtask

  task automatic t_single();
    int p = frames;
    tx_buf[0] = 8'h7E;
    send_frame(1, 0, -1, -1);
    check_frame(1, 0, p, "R9");
    p = frames;
    tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'h00;
    send_frame(3, 1, -1, -1);
    check_frame(3, 1, p, "R2");
  endtask

  task automatic t_underrun();
    int p = frames, a = aborts, f;
    int t = 0;
    tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56; tx_buf[3] = 8'h78;
    send_frame(4, 0, 2, -1);
    while (aborts == a && t < 5000) begin @(negedge clk); t++; end
    chk(aborts == a + 1, "R6", "abort seen", aborts, a + 1);
    f = flags;
    repeat (60) @(negedge clk);
    chk(flags >= f + 2, "R6", "flags after abort", flags - f, 2);
    chk(frames == p, "R6", "no frame from aborted data", frames, p);
    p = frames;
    send_frame(4, 0, -1, -1);
    check_frame(4, 0, p, "R6");
  endtask

  task automatic t_discard();
    int p = frames;
    @(negedge clk);
    in_valid = 1; in_sop = 0; in_eop = 1; in_data = 8'h99;
    while (1) begin
      bit ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 0; in_eop = 0;
    repeat (150) @(negedge clk);
    chk(frames == p, "R8", "no frame from unmarked byte", frames, p);
    chk(bad == 0, "R8", "line stays aligned", bad, 0);
    tx_buf[0] = 8'h55; tx_buf[1] = 8'hAA;
    send_frame(2, 1, -1, -1);
    check_frame(2, 1, p, "R8");
  endtask

  task automatic t_hold();
    logic v;
    int r;
    @(negedge clk);
    hold = 1;
    @(negedge clk);
    v = tx_bit; r = raw_n;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(tx_bit == v, "R7", "tx_bit held", tx_bit, v);
      chk(in_ready == 1'b0, "R9", "no ready without enable", in_ready, 0);
      if (tx_bit != v) break;
    end
    chk(raw_n == r, "R7", "no bits while held", raw_n, r);
    hold = 0;
  endtask

  task automatic t_mode_switch();
    int p = frames;
    for (int i = 0; i < 5; i++) tx_buf[i] = 8'h10 * 8'(i) + 8'h3;
    send_frame(5, 0, -1, 2);
    crc32_sel = 0;
    check_frame(5, 0, p, "R10");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_idle();
    t_ccitt_vector();
    t_crc32_vector();
    t_all_ones();
    t_single();
    t_underrun();
    t_discard();
    t_hold();
    t_mode_switch();
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule